// File: doc/BRIEF.md
# Integer ALU with Registered Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. It combines two operands under a 4-bit opcode and produces a result and a result write-enable in the same cycle. Four condition flags (negative, zero, carry, overflow) are held in a small status register inside the block. The arithmetic core reads that register's stored carry for the carry-using forms.

Twelve opcodes compute a value that is written back: add, add with carry, subtract, subtract with carry, reverse subtract, reverse subtract with carry, AND, OR, XOR, bit clear, move and move-inverted. Four more opcodes compare or test. They compute an internal value, deassert the write-enable and always load the flags. For every other opcode the flags change only when the set-flags input is high. For logical and move opcodes the carry flag is loaded from a separate shifter carry input and the overflow flag keeps its value.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcode 4 (ADD) gives a+b and opcode 5 (ADC) gives a+b+C, where C is the stored carry flag; both assert result_we.
- R2: Opcode 2 (SUB) gives a-b, opcode 6 (SBC) gives a-b+C-1, opcode 3 (RSB) gives b-a and opcode 7 (RSC) gives b-a+C-1; all assert result_we.
- R3: Opcode 0 gives a AND b, opcode 12 gives a OR b, opcode 1 gives a XOR b and opcode 14 gives a AND NOT b; all assert result_we.
- R4: Opcode 13 passes b to the result unchanged and opcode 15 gives NOT b; both assert result_we.
- R5: Opcodes 8 (a AND b), 9 (a XOR b), 10 (a-b) and 11 (a+b) hold result_we low and load the flags from that internal value whatever the level of set_flags.
- R6: On a flag load, N takes bit 31 of the computed value and Z is 1 exactly when that value is zero.
- R7: On a flag load by an arithmetic opcode (2 to 7, 10, 11), C takes the carry out of the addition (1 means no borrow for subtract forms, that is unsigned minuend >= subtrahend plus borrow) and V takes the two's-complement overflow.
- R8: On a flag load by a logical or move opcode (0, 1, 8, 9, 12 to 15), C takes shift_carry and V keeps its previous value.
- R9: When set_flags is low and the opcode is not 8 to 11, all four flags keep their values.
- R10: Flags change only on a rising clock edge, so a load is visible from the cycle after it. A synchronous reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag load for non-compare opcodes |
| shift_carry | input | 1 | Carry value loaded by logical and move opcodes |
| result | output | 32 | Computed value (combinational) |
| result_we | output | 1 | High when the result is to be written back |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
Result and write-enable are combinational, so they are due in the cycle the operands are applied. The bench samples them one time unit after it drives the inputs at the falling edge, and the expected values use the flags the bench model holds at that moment. The flags are due one rising edge later. The bench samples them one time unit after that edge, and only after that does it advance its own flag model. A flag load and a carry-using operation in the next cycle are therefore checked in the right order.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,
      OP_XOR = 4'd1,
      OP_SUB = 4'd2,
      OP_RSB = 4'd3,
      OP_ADD = 4'd4,
      OP_ADC = 4'd5,
      OP_SBC = 4'd6,
      OP_RSC = 4'd7,
      OP_TST = 4'd8,
      OP_TEQ = 4'd9,
      OP_CMP = 4'd10,
      OP_CMN = 4'd11,
      OP_ORR = 4'd12,
      OP_MOV = 4'd13,
      OP_BIC = 4'd14,
      OP_MVN = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   // compare/test group: value discarded, flags always loaded
   function automatic logic op_is_compare(input logic [3:0] op);
      return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
   endfunction

   // operations that pass through the adder
   function automatic logic op_is_arith(input logic [3:0] op);
      case (op)
         OP_SUB, OP_RSB, OP_ADD, OP_ADC,
         OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
         default:                       return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int  WIDTH      = 32,
   parameter bit  RIPPLE     = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2) else $error("alu_adder: WIDTH must be at least 2");
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign cout = chain[WIDTH];
         assign ovf  = chain[WIDTH] ^ chain[MSB];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[WIDTH];
         assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
      end
   endgenerate

endmodule

// File: rtl/alu_arith.sv
module alu_arith
   import alu_flags_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] value,
   output logic             cout,
   output logic             ovf
);
   logic             swap;
   logic             invert;
   logic [WIDTH-1:0] x_opnd;
   logic [WIDTH-1:0] y_raw;
   logic [WIDTH-1:0] y_opnd;
   logic             cin_sel;

   always_comb begin
      swap    = 1'b0;
      invert  = 1'b0;
      cin_sel = 1'b0;
      case (op)
         OP_ADD, OP_CMN: begin invert = 1'b0; cin_sel = 1'b0;     end
         OP_ADC:         begin invert = 1'b0; cin_sel = carry_in; end
         OP_SUB, OP_CMP: begin invert = 1'b1; cin_sel = 1'b1;     end
         OP_SBC:         begin invert = 1'b1; cin_sel = carry_in; end
         OP_RSB:         begin swap = 1'b1; invert = 1'b1; cin_sel = 1'b1;     end
         OP_RSC:         begin swap = 1'b1; invert = 1'b1; cin_sel = carry_in; end
         default:        begin swap = 1'b0; invert = 1'b0; cin_sel = 1'b0;     end
      endcase
   end

   assign x_opnd = swap ? b : a;
   assign y_raw  = swap ? a : b;
   assign y_opnd = invert ? ~y_raw : y_raw;

   alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x    (x_opnd),
      .y    (y_opnd),
      .cin  (cin_sel),
      .sum  (value),
      .cout (cout),
      .ovf  (ovf)
   );

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_flags_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] value
);
   always_comb begin
      case (op)
         OP_AND, OP_TST: value = a & b;
         OP_XOR, OP_TEQ: value = a ^ b;
         OP_ORR:         value = a | b;
         OP_BIC:         value = a & ~b;
         OP_MOV:         value = b;
         OP_MVN:         value = ~b;
         default:        value = '0;
      endcase
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flags_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic       load_v,
   input  alu_flags_t next,
   output alu_flags_t cur
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cur <= '0;
      end else if (load) begin
         cur.n <= next.n;
         cur.z <= next.z;
         cur.c <= next.c;
         if (load_v) cur.v <= next.v;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cur == '0)); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cur)); // R9
   AST_V_KEPT: assert property (@(posedge clk) disable iff (rst)
      (load && !load_v) |=> (cur.v == $past(cur.v))); // R8
   AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (load && load_v) |=> (cur == $past(next))); // R10

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
   import alu_flags_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [3:0]       opcode,
   input  logic             set_flags,
   input  logic             shift_carry,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   localparam int MSB = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2) else $error("alu_flags_unit: WIDTH must be at least 2");
   end

   alu_flags_t       flags_q;
   alu_flags_t       flags_d;
   logic [WIDTH-1:0] arith_val;
   logic [WIDTH-1:0] logic_val;
   logic [WIDTH-1:0] comp_val;
   logic             add_cout;
   logic             add_ovf;
   logic             sel_arith;
   logic             sel_cmp;
   logic             do_load;

   assign sel_arith = op_is_arith(opcode);
   assign sel_cmp   = op_is_compare(opcode);

   alu_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .op       (opcode),
      .a        (op_a),
      .b        (op_b),
      .carry_in (flags_q.c),
      .value    (arith_val),
      .cout     (add_cout),
      .ovf      (add_ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op    (opcode),
      .a     (op_a),
      .b     (op_b),
      .value (logic_val)
   );

   assign comp_val  = sel_arith ? arith_val : logic_val;
   assign result    = comp_val;
   assign result_we = ~sel_cmp;
   assign do_load   = set_flags | sel_cmp;

   always_comb begin
      flags_d.n = comp_val[MSB];
      flags_d.z = (comp_val == '0);
      flags_d.c = sel_arith ? add_cout : shift_carry;
      flags_d.v = add_ovf;
   end

   alu_flag_reg u_flags (
      .clk    (clk),
      .rst    (rst),
      .load   (do_load),
      .load_v (sel_arith),
      .next   (flags_d),
      .cur    (flags_q)
   );

   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_c = flags_q.c;
   assign flag_v = flags_q.v;

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (opcode inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN}) |-> !result_we); // R5
   AST_CMP_LOADS: assert property (@(posedge clk) disable iff (rst)
      (opcode inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN}) |=> (flag_z == ($past(comp_val) == '0))); // R5
   AST_Z_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      set_flags |=> (flag_z == ($past(result) == '0))); // R6
   AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      set_flags |=> (flag_n == $past(result[MSB]))); // R6
   AST_LOGIC_C_SRC: assert property (@(posedge clk) disable iff (rst)
      (set_flags && (opcode inside {OP_AND, OP_XOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN}))
      |=> (flag_c == $past(shift_carry))); // R8

endmodule

// File: tb/sim_alu_flags_unit.sv
`timescale 1ns/1ps
module sim_alu_flags_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] op_a;
   logic [31:0] op_b;
   logic [3:0]  opcode;
   logic        set_flags;
   logic        shift_carry;
   logic [31:0] result;
   logic        result_we;
   logic        flag_n, flag_z, flag_c, flag_v;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   // model flags
   logic m_n, m_z, m_c, m_v;

   always #2.5 clk = ~clk;

   alu_flags_unit u0 (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
      .set_flags(set_flags), .shift_carry(shift_carry), .result(result),
      .result_we(result_we), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_cmp(input logic [3:0] op);
      return op >= 4'd8 && op <= 4'd11;
   endfunction

   function automatic bit is_arith(input logic [3:0] op);
      return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
   endfunction

   // expected value and arithmetic carry/overflow from the requirement formulas
   task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                        input logic cf, output logic [31:0] val, output logic co, output logic vo);
      longint ux, uy, sx, sy, full, sfull;
      logic [31:0] x, y;
      bit sub, withc, rev;
      longint cinc;
      val = '0; co = 1'b0; vo = 1'b0;
      case (op)
         4'd0, 4'd8:  val = a & b;
         4'd1, 4'd9:  val = a ^ b;
         4'd12:       val = a | b;
         4'd14:       val = a & ~b;
         4'd13:       val = b;
         4'd15:       val = ~b;
         default: begin
            sub   = (op != 4'd4 && op != 4'd5 && op != 4'd11);
            withc = (op == 4'd5 || op == 4'd6 || op == 4'd7);
            rev   = (op == 4'd3 || op == 4'd7);
            x = rev ? b : a;
            y = rev ? a : b;
            ux = longint'({32'b0, x});
            uy = longint'({32'b0, y});
            sx = longint'(signed'(x));
            sy = longint'(signed'(y));
            cinc = withc ? longint'(cf) : (sub ? 64'sd1 : 64'sd0);
            if (sub) begin
               full  = ux - uy - (1 - cinc);
               sfull = sx - sy - (1 - cinc);
               co    = (ux >= uy + (1 - cinc));
            end else begin
               full  = ux + uy + cinc;
               sfull = sx + sy + cinc;
               co    = (full > 64'sh0000_0000_FFFF_FFFF);
            end
            vo  = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
            val = full[31:0];
         end
      endcase
   endtask

   task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                       input logic sf, input logic sc, input string tag);
      logic [31:0] ev;
      logic ec, evv;
      bit load;
      @(negedge clk);
      op_a = a; op_b = b; opcode = op; set_flags = sf; shift_carry = sc;
      #1;
      model(a, b, op, m_c, ev, ec, evv);
      if (!is_cmp(op)) check({tag, " result"}, {32'b0, result}, {32'b0, ev});
      check(is_cmp(op) ? "R5 result_we" : {tag, " result_we"}, {63'b0, result_we}, {63'b0, !is_cmp(op)});
      load = sf || is_cmp(op);
      @(posedge clk);
      #1;
      if (load) begin
         m_n = ev[31];
         m_z = (ev == 32'b0);
         if (is_arith(op)) begin m_c = ec; m_v = evv; end
         else m_c = sc;
      end
      check(load ? (is_arith(op) ? "R6/R7 flags" : "R6/R8 flags") : "R9 flags held",
            {60'b0, flag_n, flag_z, flag_c, flag_v}, {60'b0, m_n, m_z, m_c, m_v});
   endtask

   function automatic string tag_of(input logic [3:0] op);
      if (is_cmp(op)) return "R5";
      if (op == 4'd4 || op == 4'd5) return "R1";
      if (op >= 4'd2 && op <= 4'd7) return "R2";
      if (op == 4'd13 || op == 4'd15) return "R4";
      return "R3";
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1; op_a = '0; op_b = '0; opcode = 4'd13; set_flags = 1'b0; shift_carry = 1'b0;
      m_n = 0; m_z = 0; m_c = 0; m_v = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset flags", {60'b0, flag_n, flag_z, flag_c, flag_v}, 64'd0);
      @(negedge clk); rst = 1'b0;

      // R1 corner cases: signed overflow, unsigned carry to zero, ADC uses C
      step(32'h7FFF_FFFF, 32'h0000_0001, 4'd4, 1'b1, 1'b0, "R1");
      step(32'hFFFF_FFFF, 32'h0000_0001, 4'd4, 1'b1, 1'b0, "R1");
      step(32'h0000_0010, 32'h0000_0020, 4'd5, 1'b0, 1'b0, "R1");
      // R2: equal subtract gives Z and C, smaller minuend gives borrow
      step(32'h0000_0005, 32'h0000_0005, 4'd2, 1'b1, 1'b0, "R2");
      step(32'h0000_0003, 32'h0000_0005, 4'd2, 1'b1, 1'b0, "R2");
      step(32'h0000_0003, 32'h0000_0005, 4'd6, 1'b0, 1'b0, "R2");
      step(32'h0000_0003, 32'h0000_0005, 4'd3, 1'b1, 1'b0, "R2");
      step(32'h0000_0003, 32'h0000_0005, 4'd7, 1'b1, 1'b0, "R2");
      step(32'h8000_0000, 32'h0000_0001, 4'd2, 1'b1, 1'b0, "R7");
      // R3 / R4 with flag loads: C from shift_carry, V kept
      step(32'hA5A5_F00F, 32'hFFFF_0000, 4'd14, 1'b1, 1'b1, "R3");
      step(32'h1234_5678, 32'h1234_5678, 4'd1, 1'b1, 1'b0, "R8");
      step(32'h0000_0000, 32'h0F0F_0000, 4'd15, 1'b1, 1'b1, "R4");
      step(32'hDEAD_BEEF, 32'h0000_0000, 4'd13, 1'b1, 1'b0, "R4");
      // R5: compares load flags with set_flags low and write nothing
      step(32'h0000_0007, 32'h0000_0007, 4'd10, 1'b0, 1'b0, "R5");
      step(32'hFFFF_FFFF, 32'h0000_0001, 4'd11, 1'b0, 1'b0, "R5");
      step(32'hF0F0_0000, 32'h0F0F_0000, 4'd8, 1'b0, 1'b1, "R5");
      step(32'h8000_0001, 32'h0000_0001, 4'd9, 1'b0, 1'b0, "R5");
      // R9: no set_flags, flags hold across add and logic ops
      step(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'd4, 1'b0, 1'b1, "R9");
      step(32'h0000_0000, 32'h0000_0000, 4'd0, 1'b0, 1'b1, "R9");

      for (int i = 0; i < 600; i++) begin
         logic [3:0] op;
         op = 4'($urandom_range(0, 15));
         step($urandom, ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom, op,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), tag_of(op));
      end

      // R10: set flags, then synchronous reset clears them
      step(32'h8000_0000, 32'h8000_0000, 4'd4, 1'b1, 1'b0, "R10");
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R10 sync reset", {60'b0, flag_n, flag_z, flag_c, flag_v}, 64'd0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule